// File: doc/BRIEF.md
# Memory Access Error Capture Unit

This unit sits beside a memory controller and records faulting accesses of three kinds: an address that decodes to no memory, a lookup that hits an invalid entry of the address translation table, and an access that breaks a security rule. Each kind has its own capture slot holding a status word (the requester's client number, whether the access was a write, and for security faults which of two violation types occurred) and the 32-bit faulting address.

A set slot raises a sticky bit in a shared interrupt status register. A mask register selects which bits drive the interrupt line. Software reads the slots over a simple register port and writes 1 to a status bit to release it. A slot keeps the first fault it saw until software releases it. If a new fault arrives in the same cycle as the release, the new fault is stored and the bit stays set.

Top module: `memerr_capture`

## Requirements
- R1: After reset the interrupt status register, the mask register, `irq_o` and `cfg_rdata` are all zero.
- R2: A one-cycle strobe on `err_vld[c]` sets interrupt status bit c at the next clock edge. Bit 0 is the decode class, bit 1 the invalid-page class and bit 2 the security class. The interrupt status register is at offset 0x00.
- R3: The decode status word (offset 0x10) holds the client number in bits 5:0 and the write flag in bit 31. All other bits are zero.
- R4: The invalid-page status word (offset 0x18) holds the write flag in bit 0 and the client number in bits 6:1. All other bits are zero.
- R5: The security status word (offset 0x20) holds the client number in bits 5:0, the violation type (`sec_kind`) in bit 30 and the write flag in bit 31. All other bits are zero.
- R6: Each class's faulting address is read at its status word offset plus 4 (0x14, 0x1C, 0x24).
- R7: While a class's status bit is set and not being cleared, further faults of that class leave its status word and address unchanged.
- R8: A write to offset 0x00 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R9: When a fault of class c arrives in the same cycle as a write that clears bit c, bit c stays set and the slot captures the new fault.
- R10: `irq_o` is high in the cycle after a cycle in which any status bit and its mask bit (mask register at offset 0x04, bits 2:0) are both set, and low otherwise.
- R11: Read data appears on `cfg_rdata` one cycle after `cfg_rd_en`. Unmapped or unaligned offsets read as zero. Writes to the status-word and address offsets have no effect.
- R12: Faults of different classes in the same cycle are each captured in their own slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_vld | input | 3 | Per-class fault strobe (0 decode, 1 page, 2 security) |
| err_client | input | 3x6 | Per-class requester client number |
| err_wr | input | 3 | Per-class write flag |
| err_addr | input | 3x32 | Per-class faulting address |
| sec_kind | input | 1 | Security violation type |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Masked interrupt line |

## Verification
Each class is driven with both write-flag values, extreme client numbers and both security types. These patterns show whether each field lands at its own bit position, and whether the layouts of the three classes are kept apart. A second fault on a pending slot tells first-fault holding apart from overwrite. A fault in the same cycle as its own release tells the "new fault wins" priority apart from "clear wins". All three strobes in one cycle expose any cross-class sharing. The mask is toggled with faults pending on matching and non-matching classes, which checks the gating of the interrupt line.

// File: rtl/memerr_pkg.sv
package memerr_pkg;
  localparam int NUM_CLS = 3;
  localparam int WORD_W  = 32;

  typedef enum int {
    CLS_DEC  = 0,
    CLS_PAGE = 1,
    CLS_SEC  = 2
  } err_cls_e;

  localparam int OFS_INT_STAT  = 'h00;
  localparam int OFS_INT_MASK  = 'h04;
  localparam int OFS_SLOT_BASE = 'h10;
  localparam int SLOT_STRIDE   = 8;

  // Status word offset of a slot; its address register is 4 bytes above.
  function automatic int slot_word_ofs(int c);
    return OFS_SLOT_BASE + c * SLOT_STRIDE;
  endfunction
endpackage

// File: rtl/memerr_word_fmt.sv
module memerr_word_fmt
  import memerr_pkg::*;
#(
  parameter int CLS   = CLS_DEC,
  parameter int CID_W = 6
) (
  input  logic [CID_W-1:0]  client,
  input  logic              wr,
  input  logic              kind,
  output logic [WORD_W-1:0] word
);
  generate
    if (CLS == CLS_DEC) begin : g_dec
      logic fmt_unused;
      assign fmt_unused = kind;
      always_comb begin
        word = '0;
        word[CID_W-1:0] = client;
        word[31] = wr;
      end
    end else if (CLS == CLS_PAGE) begin : g_page
      logic fmt_unused;
      assign fmt_unused = kind;
      always_comb begin
        word = '0;
        word[0] = wr;
        word[CID_W:1] = client;
      end
    end else begin : g_sec
      always_comb begin
        word = '0;
        word[CID_W-1:0] = client;
        word[30] = kind;
        word[31] = wr;
      end
    end
  endgenerate
endmodule

// File: rtl/memerr_slot.sv
module memerr_slot
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_vld,
  input  logic [WORD_W-1:0] err_word,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              clr,
  output logic              pend_o,
  output logic [WORD_W-1:0] word_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic take;

  // A free slot, or one being released this cycle, accepts the fault.
  assign take = err_vld && (!pend_o || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      word_o <= '0;
      addr_o <= '0;
    end else begin
      if (take) begin
        pend_o <= 1'b1;
        word_o <= err_word;
        addr_o <= err_addr;
      end else if (clr) begin
        pend_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/memerr_regs.sv
module memerr_regs
  import memerr_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int ADDR_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [REG_AW-1:0]              addr,
  input  logic [WORD_W-1:0]              wdata,
  input  logic [NUM_CLS-1:0]             pend,
  input  logic [NUM_CLS-1:0][WORD_W-1:0] words,
  input  logic [NUM_CLS-1:0][ADDR_W-1:0] addrs,
  output logic [NUM_CLS-1:0]             clr,
  output logic [NUM_CLS-1:0]             mask_o,
  output logic [WORD_W-1:0]              rdata,
  output logic                           irq_o
);
  logic [WORD_W-1:0] rd_mux;
  logic              wdata_unused;

  assign wdata_unused = ^wdata[WORD_W-1:NUM_CLS];
  assign clr = (wr_en && addr == REG_AW'(OFS_INT_STAT)) ? wdata[NUM_CLS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
    end else if (wr_en && addr == REG_AW'(OFS_INT_MASK)) begin
      mask_o <= wdata[NUM_CLS-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr == REG_AW'(OFS_INT_STAT)) rd_mux[NUM_CLS-1:0] = pend;
    if (addr == REG_AW'(OFS_INT_MASK)) rd_mux[NUM_CLS-1:0] = mask_o;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (addr == REG_AW'(slot_word_ofs(c)))     rd_mux = words[c];
      if (addr == REG_AW'(slot_word_ofs(c) + 4)) rd_mux = WORD_W'(addrs[c]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq_o <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      irq_o <= |(pend & mask_o);
    end
  end
endmodule

// File: rtl/memerr_capture.sv
module memerr_capture
  import memerr_pkg::*;
#(
  parameter int CID_W  = 6,
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_CLS-1:0]             err_vld,
  input  logic [NUM_CLS-1:0][CID_W-1:0]  err_client,
  input  logic [NUM_CLS-1:0]             err_wr,
  input  logic [NUM_CLS-1:0][ADDR_W-1:0] err_addr,
  input  logic                           sec_kind,
  input  logic                           cfg_wr_en,
  input  logic                           cfg_rd_en,
  input  logic [REG_AW-1:0]              cfg_addr,
  input  logic [WORD_W-1:0]              cfg_wdata,
  output logic [WORD_W-1:0]              cfg_rdata,
  output logic                           irq_o
);
  logic [NUM_CLS-1:0]             pend_q;
  logic [NUM_CLS-1:0]             clr_vec;
  logic [NUM_CLS-1:0]             mask_q;
  logic [NUM_CLS-1:0][WORD_W-1:0] fmt_word;
  logic [NUM_CLS-1:0][WORD_W-1:0] slot_word;
  logic [NUM_CLS-1:0][ADDR_W-1:0] slot_addr;

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    memerr_word_fmt #(.CLS(c), .CID_W(CID_W)) fmt_i (
      .client (err_client[c]),
      .wr     (err_wr[c]),
      .kind   (sec_kind),
      .word   (fmt_word[c])
    );
    memerr_slot #(.ADDR_W(ADDR_W)) slot_i (
      .clk      (clk),
      .rst      (rst),
      .err_vld  (err_vld[c]),
      .err_word (fmt_word[c]),
      .err_addr (err_addr[c]),
      .clr      (clr_vec[c]),
      .pend_o   (pend_q[c]),
      .word_o   (slot_word[c]),
      .addr_o   (slot_addr[c])
    );
  end

  memerr_regs #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) regs_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_wr_en),
    .rd_en  (cfg_rd_en),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .pend   (pend_q),
    .words  (slot_word),
    .addrs  (slot_addr),
    .clr    (clr_vec),
    .mask_o (mask_q),
    .rdata  (cfg_rdata),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/memerr_capture_chk.sv
module memerr_capture_chk
  import memerr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int REG_AW = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic [NUM_CLS-1:0]             err_vld,
  input logic [NUM_CLS-1:0]             clr,
  input logic [NUM_CLS-1:0]             pend,
  input logic [NUM_CLS-1:0]             mask,
  input logic [NUM_CLS-1:0][WORD_W-1:0] words,
  input logic [NUM_CLS-1:0][ADDR_W-1:0] addrs,
  input logic                           rd_en,
  input logic [REG_AW-1:0]              rd_addr,
  input logic [WORD_W-1:0]              rdata,
  input logic                           irq
);
  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    // R2
    fault_sets_bit_chk: assert property (@(posedge clk) disable iff (rst)
      err_vld[c] |=> pend[c]);
    // R7
    first_fault_held_chk: assert property (@(posedge clk) disable iff (rst)
      (pend[c] && !clr[c]) |=> ($stable(words[c]) && $stable(addrs[c])));
    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[c] && !err_vld[c]) |=> !pend[c]);
    // R9
    new_fault_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[c] && err_vld[c] && pend[c]) |=> pend[c]);
  end

  // R10
  irq_gated_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(pend & mask)));

  // R11
  mask_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == REG_AW'(OFS_INT_MASK)) |=> rdata == WORD_W'($past(mask)));
endmodule

bind memerr_capture memerr_capture_chk #(.ADDR_W(ADDR_W), .REG_AW(REG_AW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .err_vld (err_vld),
  .clr     (clr_vec),
  .pend    (pend_q),
  .mask    (mask_q),
  .words   (slot_word),
  .addrs   (slot_addr),
  .rd_en   (cfg_rd_en),
  .rd_addr (cfg_addr),
  .rdata   (cfg_rdata),
  .irq     (irq_o)
);

// File: tb/memerr_capture_tb.sv
module memerr_capture_tb_top;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       err_vld = '0;
  logic [2:0][5:0]  err_client = '0;
  logic [2:0]       err_wr = '0;
  logic [2:0][31:0] err_addr = '0;
  logic             sec_kind = 1'b0;
  logic             cfg_wr_en = 1'b0;
  logic             cfg_rd_en = 1'b0;
  logic [7:0]       cfg_addr = '0;
  logic [31:0]      cfg_wdata = '0;
  logic [31:0]      cfg_rdata;
  logic             irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memerr_capture dut_i (
    .clk(clk), .rst(rst), .err_vld(err_vld), .err_client(err_client),
    .err_wr(err_wr), .err_addr(err_addr), .sec_kind(sec_kind),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_rd_en = 1'b1; cfg_addr = a;
    @(negedge clk);
    cfg_rd_en = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic fire(int c, logic [5:0] cid, logic w, logic [31:0] a, logic k);
    @(negedge clk);
    err_vld[c] = 1'b1; err_client[c] = cid; err_wr[c] = w; err_addr[c] = a;
    sec_kind = k;
    @(negedge clk);
    err_vld = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 rdata", cfg_rdata, 0);
    rd(8'h00, d); chk("R1 status", d, 0);
    rd(8'h04, d); chk("R1 mask", d, 0);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    fire(0, 6'h2A, 1'b1, 32'h8000_1234, 1'b0);
    rd(8'h00, d); chk("R2 decode bit", d, 32'h1);
    rd(8'h10, d); chk("R3 decode word", d, 32'h8000_002A);
    rd(8'h14, d); chk("R6 decode addr", d, 32'h8000_1234);
    wr(8'h00, 32'h7);
    fire(0, 6'h3F, 1'b0, 32'h0, 1'b0);
    rd(8'h10, d); chk("R3 decode read word", d, 32'h0000_003F);
    wr(8'h00, 32'h7);
  endtask

  task automatic t_page();
    logic [31:0] d;
    fire(1, 6'h15, 1'b1, 32'hDEAD_BEE0, 1'b0);
    rd(8'h00, d); chk("R2 page bit", d, 32'h2);
    rd(8'h18, d); chk("R4 page word", d, 32'h0000_002B);
    rd(8'h1C, d); chk("R6 page addr", d, 32'hDEAD_BEE0);
    wr(8'h00, 32'h7);
    fire(1, 6'h3F, 1'b0, 32'h1, 1'b0);
    rd(8'h18, d); chk("R4 page read word", d, 32'h0000_007E);
    wr(8'h00, 32'h7);
  endtask

  task automatic t_sec();
    logic [31:0] d;
    fire(2, 6'h07, 1'b1, 32'h0000_F00C, 1'b1);
    rd(8'h00, d); chk("R2 sec bit", d, 32'h4);
    rd(8'h20, d); chk("R5 sec word", d, 32'hC000_0007);
    rd(8'h24, d); chk("R6 sec addr", d, 32'h0000_F00C);
    wr(8'h00, 32'h7);
    fire(2, 6'h3F, 1'b0, 32'h2, 1'b0);
    rd(8'h20, d); chk("R5 sec type0 read", d, 32'h0000_003F);
    wr(8'h00, 32'h7);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    fire(0, 6'h01, 1'b0, 32'hAAAA_0000, 1'b0);
    fire(0, 6'h02, 1'b1, 32'hBBBB_0000, 1'b0);
    rd(8'h10, d); chk("R7 held word", d, 32'h0000_0001);
    rd(8'h14, d); chk("R7 held addr", d, 32'hAAAA_0000);
    wr(8'h00, 32'h7);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    fire(0, 6'h01, 1'b0, 32'h10, 1'b0);
    fire(1, 6'h01, 1'b0, 32'h20, 1'b0);
    wr(8'h00, 32'h2);
    rd(8'h00, d); chk("R8 clear one", d, 32'h1);
    wr(8'h00, 32'h0);
    rd(8'h00, d); chk("R8 zero keeps", d, 32'h1);
    wr(8'h00, 32'h7);
    rd(8'h00, d); chk("R8 clear all", d, 32'h0);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    fire(0, 6'h05, 1'b0, 32'h1111_1111, 1'b0);
    @(negedge clk);
    err_vld[0] = 1'b1; err_client[0] = 6'h09; err_wr[0] = 1'b1;
    err_addr[0] = 32'h2222_2222;
    cfg_wr_en = 1'b1; cfg_addr = 8'h00; cfg_wdata = 32'h1;
    @(negedge clk);
    err_vld = '0; cfg_wr_en = 1'b0;
    rd(8'h00, d); chk("R9 bit stays", d, 32'h1);
    rd(8'h10, d); chk("R9 new word", d, 32'h8000_0009);
    rd(8'h14, d); chk("R9 new addr", d, 32'h2222_2222);
    wr(8'h00, 32'h7);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    fire(0, 6'h01, 1'b0, 32'h0, 1'b0);
    @(negedge clk); chk("R10 masked off", 32'(irq_o), 0);
    wr(8'h04, 32'h2);
    @(negedge clk); chk("R10 other mask", 32'(irq_o), 0);
    wr(8'h04, 32'h1);
    @(negedge clk); chk("R10 irq high", 32'(irq_o), 1);
    rd(8'h04, d); chk("R10 mask readback", d, 32'h1);
    wr(8'h00, 32'h1);
    @(negedge clk); chk("R10 irq low", 32'(irq_o), 0);
    wr(8'h04, 32'h0);
  endtask

  task automatic t_bus();
    logic [31:0] d;
    fire(1, 6'h0C, 1'b0, 32'h5555_0000, 1'b0);
    rd(8'h08, d); chk("R11 unmapped", d, 0);
    rd(8'h19, d); chk("R11 unaligned", d, 0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h1C, 32'h0);
    rd(8'h18, d); chk("R11 word ro", d, 32'h0000_0018);
    rd(8'h1C, d); chk("R11 addr ro", d, 32'h5555_0000);
    wr(8'h00, 32'h7);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    @(negedge clk);
    err_vld = 3'b111;
    err_client[0] = 6'h11; err_wr[0] = 1'b0; err_addr[0] = 32'hA0;
    err_client[1] = 6'h22; err_wr[1] = 1'b1; err_addr[1] = 32'hB0;
    err_client[2] = 6'h33; err_wr[2] = 1'b0; err_addr[2] = 32'hC0;
    sec_kind = 1'b1;
    @(negedge clk);
    err_vld = '0;
    rd(8'h00, d); chk("R12 all bits", d, 32'h7);
    rd(8'h10, d); chk("R12 dec word", d, 32'h0000_0011);
    rd(8'h18, d); chk("R12 page word", d, 32'h0000_0045);
    rd(8'h20, d); chk("R12 sec word", d, 32'h4000_0033);
    rd(8'h24, d); chk("R12 sec addr", d, 32'h0000_00C0);
    wr(8'h00, 32'h7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_decode();
    t_page();
    t_sec();
    t_hold();
    t_w1c();
    t_collide();
    t_irq();
    t_bus();
    t_multi();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule